// File: doc/BRIEF.md
# Dual-Output Waveform Timer

This block is a single timer channel that produces two pulse-width outputs from one shared up-counter. A period register sets the wrap point of the counter, so both outputs always run at the same frequency. Each output has its own compare register, and its level changes according to three programmable actions. One action fires when the counter matches that output's compare register. One fires when the counter matches the period register. One fires when software issues a trigger through the command register. Each action is none, set, clear or toggle.

Software programs the block through a small word-wide register port with a single write strobe and a combinational read path. A command write can enable counting, freeze it, or issue a software trigger. The trigger restarts the count from zero and applies the trigger levels on the same clock edge. The counter advances once per enable pulse from a free-running prescaler. That pulse is the system clock divided by 2, 8, 32 or 128, or an externally supplied slow strobe. In the variant with a generic clock, selector code 0 takes an external generic-clock strobe in place of divide-by-2.

A typical pulse-width setup uses these actions: clear on the compare match, set on the period match, set on the trigger. An inverted waveform swaps set and clear. For a constant level, both compare-driven actions are set to none and the trigger action decides the level.

Top module: `dual_wave_timer`

## Requirements
- R1: Reset clears the counter to 0 and drives both waves low. It leaves counting stopped until an enable command arrives. Every readable register reads 0 after reset.
- R2: While running, the counter moves on each selected tick. If the count equals the period register, the next value is 0. Otherwise the next value is the count plus one.
- R3: Clock-select field mode[2:0] chooses the tick source. Code 0 gives the clock divided by 2, code 1 divided by 8, code 2 divided by 32 and code 3 divided by 128, all taken from a prescaler that runs freely from reset. Codes 4 to 7 use the slow_tick input. With GEN_CLK set, code 0 uses gen_tick instead.
- R4: Wave A follows three action fields. mode[4:3] applies on a compare-A match, mode[6:5] on a period match and mode[8:7] on a software trigger. The action codes are 0 none, 1 set, 2 clear and 3 toggle. A match counts only on a tick while running.
- R5: Wave B follows three action fields. mode[10:9] applies on a compare-B match, mode[12:11] on a period match and mode[14:13] on a software trigger. The action codes are the same as for wave A.
- R6: When a compare match and a period match happen on the same tick, only the period action is applied.
- R7: A command write with bit 2 set resets the counter to 0 at that edge. It applies both trigger actions at that edge, and they override any compare or period event of the same cycle.
- R8: Command bit 0 starts counting and bit 1 stops it. When both are set, stop wins. While stopped, the count and both waves hold.
- R9: Register addresses are 0 for mode, 1 for compare A, 2 for compare B, 3 for period, 4 for command (write-only, reads 0) and 5 for the live count (read-only). Written registers read back their last value.
- R10: With compare and period actions set to none, each wave keeps the level its trigger action gave it across any number of periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Combinational read data |
| slow_tick | input | 1 | One-cycle strobe of the slow clock source |
| gen_tick | input | 1 | One-cycle strobe of the generic clock source |
| wave_a | output | 1 | Waveform output A |
| wave_b | output | 1 | Waveform output B |
| count | output | CNT_W | Live counter value |

## Verification
The assertions take three things for granted about the inputs. Write strobes are single-cycle requests on the one write port. slow_tick and gen_tick are strobes synchronous to clk. The configuration a given event reads is the one held in the register during that cycle. The stimulus drives every input on the falling edge and keeps each strobe to one cycle. It changes mode and compare values only through ordinary writes, and it issues triggers at varied offsets, so that some land on compare and period ticks.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } act_e;

  // per-output action set, compare action in the low bits
  typedef struct packed {
    act_e trig;
    act_e per;
    act_e cmp;
  } out_cfg_t;

  // mode layout: clk_sel [2:0], wave A [8:3], wave B [14:9]
  typedef struct packed {
    out_cfg_t b;
    out_cfg_t a;
    logic [2:0] clk_sel;
  } mode_t;

  localparam int MODE_W  = $bits(mode_t);
  localparam int NUM_OUT = 2;

  localparam logic [2:0] ADR_MODE   = 3'd0;
  localparam logic [2:0] ADR_CMP_A  = 3'd1;
  localparam logic [2:0] ADR_CMP_B  = 3'd2;
  localparam logic [2:0] ADR_PERIOD = 3'd3;
  localparam logic [2:0] ADR_CMD    = 3'd4;
  localparam logic [2:0] ADR_COUNT  = 3'd5;

  localparam int CMD_EN   = 0;
  localparam int CMD_DIS  = 1;
  localparam int CMD_TRIG = 2;

  function automatic logic apply_act(act_e a, logic cur);
    case (a)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

  // trigger beats period, period beats compare
  function automatic logic next_level(out_cfg_t cfg, logic cur, logic trig,
                                      logic ev_per, logic ev_cmp);
    if (trig)        return apply_act(cfg.trig, cur);
    else if (ev_per) return apply_act(cfg.per, cur);
    else if (ev_cmp) return apply_act(cfg.cmp, cur);
    else             return cur;
  endfunction

endpackage

// File: rtl/dwt_prescaler.sv
module dwt_prescaler
  import dwt_pkg::*;
#(
  parameter int NUM_DIV = 4,
  parameter bit GEN_CLK = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       slow_tick,
  input  logic       gen_tick,
  output logic       tick
);

  localparam int PRE_W  = 2 * NUM_DIV - 1;
  localparam int SEL_IW = (NUM_DIV > 1) ? $clog2(NUM_DIV) : 1;

  logic [PRE_W-1:0]   pre_q;
  logic [NUM_DIV-1:0] taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  // tap i fires once every 2^(2i+1) cycles
  for (genvar i = 0; i < NUM_DIV; i++) begin : g_tap
    assign taps[i] = &pre_q[2*i:0];
  end

  always_comb begin
    if (int'(sel) < NUM_DIV) begin
      if (GEN_CLK && sel == 3'd0) tick = gen_tick;
      else                        tick = taps[sel[SEL_IW-1:0]];
    end else begin
      tick = slow_tick;
    end
  end

endmodule

// File: rtl/dwt_counter.sv
module dwt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             stop,
  input  logic             trig,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             ev_a,
  output logic             ev_b,
  output logic             ev_p
);

  logic step;

  assign step = tick && running;
  assign ev_p = step && (count == period);
  assign ev_a = step && (count == cmp_a);
  assign ev_b = step && (count == cmp_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     running <= 1'b0;
    else if (stop)  running <= 1'b0;
    else if (start) running <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (trig) count <= '0;
    else if (step) count <= ev_p ? '0 : count + 1'b1;
  end

endmodule

// File: rtl/dwt_wave_out.sv
module dwt_wave_out
  import dwt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  out_cfg_t cfg,
  input  logic     trig,
  input  logic     ev_per,
  input  logic     ev_cmp,
  output logic     wave
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave <= 1'b0;
    else        wave <= next_level(cfg, wave, trig, ev_per, ev_cmp);
  end

endmodule

// File: rtl/dual_wave_timer.sv
module dual_wave_timer
  import dwt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_DIV = 4,
  parameter bit GEN_CLK = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             slow_tick,
  input  logic             gen_tick,
  output logic             wave_a,
  output logic             wave_b,
  output logic [CNT_W-1:0] count
);

  mode_t            mode_q;
  logic [CNT_W-1:0] cmp_a_q, cmp_b_q, period_q;

  logic cmd_wr, cmd_start, cmd_stop, cmd_trig;
  logic tick, running, ev_a, ev_b, ev_p;

  assign cmd_wr    = wr_en && (wr_addr == ADR_CMD);
  assign cmd_start = cmd_wr && wr_data[CMD_EN];
  assign cmd_stop  = cmd_wr && wr_data[CMD_DIS];
  assign cmd_trig  = cmd_wr && wr_data[CMD_TRIG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      cmp_a_q  <= '0;
      cmp_b_q  <= '0;
      period_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_MODE:   mode_q   <= mode_t'(wr_data[MODE_W-1:0]);
        ADR_CMP_A:  cmp_a_q  <= wr_data;
        ADR_CMP_B:  cmp_b_q  <= wr_data;
        ADR_PERIOD: period_q <= wr_data;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      ADR_MODE:   rd_data = CNT_W'(mode_q);
      ADR_CMP_A:  rd_data = cmp_a_q;
      ADR_CMP_B:  rd_data = cmp_b_q;
      ADR_PERIOD: rd_data = period_q;
      ADR_COUNT:  rd_data = count;
      default:    rd_data = '0;
    endcase
  end

  dwt_prescaler #(.NUM_DIV(NUM_DIV), .GEN_CLK(GEN_CLK)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (mode_q.clk_sel),
    .slow_tick (slow_tick),
    .gen_tick  (gen_tick),
    .tick      (tick)
  );

  dwt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .start   (cmd_start),
    .stop    (cmd_stop),
    .trig    (cmd_trig),
    .cmp_a   (cmp_a_q),
    .cmp_b   (cmp_b_q),
    .period  (period_q),
    .count   (count),
    .running (running),
    .ev_a    (ev_a),
    .ev_b    (ev_b),
    .ev_p    (ev_p)
  );

  out_cfg_t             cfg_v [NUM_OUT];
  logic [NUM_OUT-1:0]   ev_cmp_v;
  logic [NUM_OUT-1:0]   wave_v;

  assign cfg_v[0]    = mode_q.a;
  assign cfg_v[1]    = mode_q.b;
  assign ev_cmp_v[0] = ev_a;
  assign ev_cmp_v[1] = ev_b;

  for (genvar c = 0; c < NUM_OUT; c++) begin : g_out
    dwt_wave_out u_wave (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg    (cfg_v[c]),
      .trig   (cmd_trig),
      .ev_per (ev_p),
      .ev_cmp (ev_cmp_v[c]),
      .wave   (wave_v[c])
    );
  end

  assign wave_a = wave_v[0];
  assign wave_b = wave_v[1];

endmodule

// File: rtl/dwt_checker.sv
module dwt_checker
  import dwt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             trig,
  input logic             running,
  input logic             ev_a,
  input logic             ev_b,
  input logic             ev_p,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] period,
  input mode_t            mode,
  input logic             wave_a,
  input logic             wave_b
);

  AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && running && !trig && count == period) |=> (count == '0)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && running && !trig && count != period) |=> (count == CNT_W'($past(count) + 1'b1))); // R2

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !trig) |=> $stable(count)); // R8

  AST_TRIG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (count == '0)); // R7

  AST_TRIG_SET_A: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && mode.a.trig == ACT_SET) |=> wave_a); // R7

  AST_A_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !ev_a && !ev_p) |=> $stable(wave_a)); // R4

  AST_B_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !ev_b && !ev_p) |=> $stable(wave_b)); // R5

  AST_PERIOD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && ev_p && ev_a && mode.a.per == ACT_CLR) |=> !wave_a); // R6

endmodule

bind dual_wave_timer dwt_checker #(.CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .trig    (cmd_trig),
  .running (running),
  .ev_a    (ev_a),
  .ev_b    (ev_b),
  .ev_p    (ev_p),
  .count   (count),
  .period  (period_q),
  .mode    (mode_q),
  .wave_a  (wave_a),
  .wave_b  (wave_b)
);

// File: tb/dual_wave_timer_tb_top.sv
`timescale 1ns/1ps
module dual_wave_timer_tb_top;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [2:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic         slow_tick = 1'b0;
  logic         gen_tick = 1'b0;
  logic         wave_a, wave_b;
  logic [W-1:0] count;

  always #2 clk = ~clk; // 250 MHz

  dual_wave_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .slow_tick(slow_tick), .gen_tick(gen_tick),
    .wave_a(wave_a), .wave_b(wave_b), .count(count)
  );

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";
  bit cmp_on = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // slow strobe every 5 cycles
  int slow_cnt = 0;
  always @(negedge clk) begin
    slow_cnt = (slow_cnt + 1) % 5;
    slow_tick <= (slow_cnt == 0);
  end

  // ---------------- behavioural reference ----------------
  int m_pre, m_cnt, m_ra, m_rb, m_rc, m_mode;
  bit m_run, m_a, m_b;

  function automatic bit act_f(int code, bit cur);
    if (code == 1) return 1'b1;
    if (code == 2) return 1'b0;
    if (code == 3) return !cur;
    return cur;
  endfunction

  function automatic int fld(int v, int lsb);
    return (v >> lsb) & 3;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_ra = 0; m_rb = 0; m_rc = 0; m_mode = 0;
      m_run = 0; m_a = 0; m_b = 0;
    end else begin
      int sel, d;
      bit tk, trg, evp, eva, evb, cw;
      sel = m_mode & 7;
      if (sel < 4) begin
        d = 2 ** (2 * sel + 1);
        tk = (m_pre % d) == d - 1;
      end else tk = slow_tick;
      cw  = wr_en && wr_addr == 3'd4;
      trg = cw && wr_data[2];
      evp = tk && m_run && m_cnt == m_rc;
      eva = tk && m_run && m_cnt == m_ra;
      evb = tk && m_run && m_cnt == m_rb;
      if (trg)      m_a = act_f(fld(m_mode, 7), m_a);
      else if (evp) m_a = act_f(fld(m_mode, 5), m_a);
      else if (eva) m_a = act_f(fld(m_mode, 3), m_a);
      if (trg)      m_b = act_f(fld(m_mode, 13), m_b);
      else if (evp) m_b = act_f(fld(m_mode, 11), m_b);
      else if (evb) m_b = act_f(fld(m_mode, 9), m_b);
      if (trg) m_cnt = 0;
      else if (tk && m_run) m_cnt = (m_cnt == m_rc) ? 0 : (m_cnt + 1) % 65536;
      if (cw) begin
        if (wr_data[1]) m_run = 0;
        else if (wr_data[0]) m_run = 1;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_mode = int'(wr_data) & 16'h7fff;
          3'd1: m_ra = int'(wr_data);
          3'd2: m_rb = int'(wr_data);
          3'd3: m_rc = int'(wr_data);
          default: ;
        endcase
      end
      m_pre = (m_pre + 1) % 128;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(int'(count) == m_cnt, cur_tag, "count", count, m_cnt);
      chk(wave_a == m_a, cur_tag, "wave_a", wave_a, m_a);
      chk(wave_b == m_b, cur_tag, "wave_b", wave_b, m_b);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input int exp, input string req);
    rd_addr = a;
    #0.5;
    chk(int'(rd_data) == exp, req, "rd_data", rd_data, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int cfg(int cmp, int per, int trg);
    return cmp | (per << 2) | (trg << 4);
  endfunction

  function automatic int mode_of(int sel, int ca, int cb);
    return sel | (ca << 3) | (cb << 9);
  endfunction

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int c0;
    bit la, lb;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(count == '0, "R1", "count after reset", count, 0);
    chk(wave_a == 1'b0, "R1", "wave_a after reset", wave_a, 0);
    chk(wave_b == 1'b0, "R1", "wave_b after reset", wave_b, 0);
    for (int a = 0; a < 6; a++) rd_chk(3'(a), 0, "R1");
    cmp_on = 1'b1;
    cur_tag = "R1";
    idle(12);
    chk(count == '0, "R1", "count stays stopped", count, 0);

    // R9 register access
    cur_tag = "R9";
    wr(3'd1, 3); wr(3'd2, 6); wr(3'd3, 9);
    wr(3'd0, mode_of(0, cfg(2, 1, 1), cfg(2, 1, 1)));
    rd_chk(3'd1, 3, "R9"); rd_chk(3'd2, 6, "R9"); rd_chk(3'd3, 9, "R9");
    rd_chk(3'd0, mode_of(0, cfg(2, 1, 1), cfg(2, 1, 1)), "R9");
    rd_chk(3'd4, 0, "R9");

    // R7 start with trigger; R2/R4/R5 normal running
    wr(3'd4, 5);
    chk(count == '0, "R7", "count after trigger", count, 0);
    chk(wave_a == 1'b1, "R7", "wave_a after trigger", wave_a, 1);
    chk(wave_b == 1'b1, "R7", "wave_b after trigger", wave_b, 1);
    cur_tag = "R2"; idle(30);
    cur_tag = "R4"; idle(30);
    rd_chk(3'd5, m_cnt, "R9");
    cur_tag = "R5";
    wr(3'd0, mode_of(0, cfg(3, 0, 2), cfg(1, 3, 0)));
    idle(60);
    cur_tag = "R4";
    wr(3'd0, mode_of(0, cfg(0, 3, 0), cfg(3, 2, 1)));
    idle(50);

    // R6 compare equal to period
    cur_tag = "R6";
    wr(3'd1, 9);
    wr(3'd0, mode_of(0, cfg(1, 2, 1), cfg(2, 3, 1)));
    wr(3'd2, 9);
    wr(3'd4, 4);
    idle(60);
    wr(3'd1, 4); wr(3'd2, 2);

    // R7 triggers at varied offsets
    cur_tag = "R7";
    wr(3'd0, mode_of(0, cfg(2, 1, 3), cfg(3, 1, 2)));
    for (int k = 0; k < 12; k++) begin
      idle(k + 1);
      wr(3'd4, 4);
    end
    idle(20);

    // R3 clock sources
    cur_tag = "R3";
    wr(3'd0, mode_of(1, cfg(2, 1, 1), cfg(2, 1, 1)));
    idle(200);
    wr(3'd0, mode_of(2, cfg(2, 1, 1), cfg(2, 1, 1)));
    idle(700);
    wr(3'd3, 3); wr(3'd1, 1); wr(3'd2, 2);
    wr(3'd0, mode_of(3, cfg(2, 1, 1), cfg(3, 0, 1)));
    idle(1600);
    wr(3'd0, mode_of(4, cfg(2, 1, 1), cfg(2, 1, 1)));
    idle(100);
    wr(3'd0, mode_of(6, cfg(3, 1, 1), cfg(2, 3, 1)));
    idle(80);

    // R8 stop, hold, both bits
    cur_tag = "R8";
    wr(3'd0, mode_of(0, cfg(3, 3, 1), cfg(3, 1, 2)));
    idle(7);
    wr(3'd4, 2);
    c0 = int'(count); la = wave_a; lb = wave_b;
    idle(30);
    chk(int'(count) == c0, "R8", "count frozen", count, c0);
    chk(wave_a == la, "R8", "wave_a held", wave_a, la);
    chk(wave_b == lb, "R8", "wave_b held", wave_b, lb);
    wr(3'd4, 3);
    idle(20);
    chk(int'(count) == c0, "R8", "stop wins over start", count, c0);
    wr(3'd4, 1);
    idle(40);

    // R10 constant levels
    cur_tag = "R10";
    wr(3'd0, mode_of(0, cfg(0, 0, 2), cfg(0, 0, 1)));
    wr(3'd4, 5);
    idle(80);
    chk(wave_a == 1'b0, "R10", "wave_a constant", wave_a, 0);
    chk(wave_b == 1'b1, "R10", "wave_b constant", wave_b, 1);
    wr(3'd0, mode_of(0, cfg(0, 0, 3), cfg(0, 0, 3)));
    wr(3'd4, 4);
    chk(wave_a == 1'b1, "R10", "wave_a toggled by trigger", wave_a, 1);
    chk(wave_b == 1'b0, "R10", "wave_b toggled by trigger", wave_b, 0);
    idle(60);

    cmp_on = 1'b0;
    summary();
    $finish;
  end

endmodule